// File: doc/BRIEF.md
# LCD raster timing generator

This block drives the timing side of a parallel RGB panel. It keeps a horizontal position counter and a vertical line counter. From them it produces a horizontal sync pulse, a vertical sync pulse, a data-enable window and a pixel request strobe for the pixel source that feeds the panel. The present positions are also brought out so that the downstream logic can follow the raster.

Software programs the raster through a small word-addressed register bus:

- the two sync pulse widths;
- one packed register holding both frame totals;
- two packed registers giving the active window as absolute start and end positions on each axis.

A configuration register selects, for each output, whether it is active high or active low.

The raster starts from position zero when software enables it. A stop request is graceful: the raster runs on to the last pixel of the current frame, then halts and raises a sticky stopped flag. Software clears that flag by writing zero to it.

Top module: `lcd_raster_timer`

## Requirements
- R1: After reset the raster is stopped. Both positions read 0, every register reads 0, the stopped flag is 0, and hsync, vsync, data-enable, pixel request and the pixel-clock-invert output are all low.
- R2: Register map, by word address:
  - 0: configuration.
  - 1: horizontal sync width, low 10 bits kept, upper bits dropped and read as 0.
  - 2: vertical sync width, same 10-bit rule as address 1.
  - 3: totals, horizontal in bits 31:16 and vertical in bits 15:0.
  - 4: horizontal window, start in 31:16 and end in 15:0.
  - 5: vertical window, same layout as address 4.
  - 6: control.
  - 7: status.
  - Addresses 0 to 5 read back what was stored, and a write takes effect on the next cycle.
- R3: While the raster runs, the horizontal position steps by one each cycle from 0 to the horizontal total minus 1 and then returns to 0. The vertical position steps by one only when the horizontal position wraps, and returns to 0 after the vertical total minus 1.
- R4: While running, the horizontal sync is at its active level exactly when the horizontal position is below the horizontal sync width. The vertical sync is at its active level exactly when the vertical position is below the vertical sync width.
- R5: While running, data-enable is at its active level exactly when the horizontal position lies in [start, end) and the vertical position lies in [start, end). The pixel request strobe is high, always active high, in exactly those cycles.
- R6: Configuration bit 11 makes hsync active low, bit 9 makes data-enable active low and bit 8 makes vsync active low. Bit 10 is driven straight onto the pixel-clock-invert output. A change of polarity takes effect on the next cycle, whether or not the raster runs.
- R7: A control write with bit 3 set and bit 4 clear starts a stopped raster. The first running cycle shows both positions at 0. Such a write has no effect while the raster is running or stopping. A write with both bits set counts only as a stop request.
- R8: A control write with bit 4 set while running lets the raster continue until the clock edge at which the last position of a frame (total minus 1 on both axes) is present. On that edge the raster stops, both positions return to 0, and the stopped flag is set. If the request lands on that very edge, one further full frame is produced. While stopped, every sync and enable output sits at its inactive level.
- R9: Status bit 0 is the stopped flag. A write to the status address with bit 0 clear clears it, a write with bit 0 set leaves it alone, and a stop request while already stopped does not set it.
- R10: Reading the control address returns bit 3 = raster active (running or stopping) and bit 4 = stop pending, all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| lcd_hsync | output | 1 | Horizontal sync, polarity per configuration |
| lcd_vsync | output | 1 | Vertical sync, polarity per configuration |
| lcd_de | output | 1 | Data-enable, polarity per configuration |
| lcd_pclk_inv | output | 1 | Pixel clock edge select for the pad logic |
| pix_req | output | 1 | Active-high request for one pixel this cycle |
| h_pos | output | 16 | Current horizontal position |
| v_pos | output | 16 | Current vertical position |

## Verification
The raster is first run with a window strictly inside the frame and separate sync widths. This separates sync timing from window timing and exposes off-by-one errors at both ends of each window. A second setup places the window flush against position 0 and against the total, uses a zero horizontal sync width, and uses a vertical sync that covers the whole frame, which catches comparisons written with the wrong strictness. Polarity is flipped while the raster runs, both all at once and in part, so that each output's inversion is seen separately. Stop requests are issued mid-frame and on the exact final edge of a frame, to tell a graceful stop from an immediate one. The bench also checks that a stop request landing on that edge yields one further full frame.

// File: rtl/lcd_rt_pkg.sv
package lcd_rt_pkg;

    typedef enum logic [1:0] {
        RS_STOP  = 2'd0,
        RS_RUN   = 2'd1,
        RS_DRAIN = 2'd2
    } run_state_e;

    // word addresses
    localparam int unsigned A_CFG   = 0;
    localparam int unsigned A_HSW   = 1;
    localparam int unsigned A_VSW   = 2;
    localparam int unsigned A_TOT   = 3;
    localparam int unsigned A_HWIN  = 4;
    localparam int unsigned A_VWIN  = 5;
    localparam int unsigned A_CTRL  = 6;
    localparam int unsigned A_STAT  = 7;

    // bit positions
    localparam int unsigned B_POL_LO   = 8;   // polarity field 11:8
    localparam int unsigned B_RUN      = 3;
    localparam int unsigned B_STOP     = 4;
    localparam int unsigned B_HALTED   = 0;

    // index inside the 4-bit polarity field
    localparam int unsigned P_VS   = 0;
    localparam int unsigned P_DE   = 1;
    localparam int unsigned P_PCLK = 2;
    localparam int unsigned P_HS   = 3;

endpackage

// File: rtl/lcd_rt_axis_counter.sv
module lcd_rt_axis_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t             cnt_d, cnt_q;
    logic [CNT_W:0]   next_ext;

    assign next_ext = {1'b0, cnt_q.count} + {{CNT_W{1'b0}}, 1'b1};
    // a total of zero or a value below the count also wraps
    assign wrap     = next_ext >= {1'b0, total};
    assign count    = cnt_q.count;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d.count = '0;
        end else if (advance) begin
            cnt_d.count = wrap ? '0 : next_ext[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && !wrap) |=> (count == $past(count) + CNT_W'(1)))
        else $error("R3: counter did not step");

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap) |=> (count == '0))
        else $error("R3: counter did not wrap");

endmodule

// File: rtl/lcd_rt_regs.sv
module lcd_rt_regs
    import lcd_rt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SYNC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              halt_evt,
    input  logic              active,
    input  logic              draining,
    output logic              ctrl_wr,
    output logic              ctrl_run,
    output logic              ctrl_stop,
    output logic [SYNC_W-1:0] hsw,
    output logic [SYNC_W-1:0] vsw,
    output logic [CNT_W-1:0]  htot,
    output logic [CNT_W-1:0]  vtot,
    output logic [CNT_W-1:0]  hbeg,
    output logic [CNT_W-1:0]  hend,
    output logic [CNT_W-1:0]  vbeg,
    output logic [CNT_W-1:0]  vend,
    output logic [3:0]        pol,
    output logic              halted
);

    localparam int unsigned HALF = DATA_W / 2;

    typedef struct packed {
        logic [SYNC_W-1:0] hsw;
        logic [SYNC_W-1:0] vsw;
        logic [CNT_W-1:0]  htot;
        logic [CNT_W-1:0]  vtot;
        logic [CNT_W-1:0]  hbeg;
        logic [CNT_W-1:0]  hend;
        logic [CNT_W-1:0]  vbeg;
        logic [CNT_W-1:0]  vend;
        logic [3:0]        pol;
        logic              halted;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [CNT_W-1:0] w_hi, w_lo;
    logic             stat_clr;

    assign w_hi      = wdata[HALF +: CNT_W];
    assign w_lo      = wdata[CNT_W-1:0];
    assign ctrl_wr   = wr && (addr == ADDR_W'(A_CTRL));
    assign ctrl_run  = wdata[B_RUN];
    assign ctrl_stop = wdata[B_STOP];
    assign stat_clr  = wr && (addr == ADDR_W'(A_STAT)) && !wdata[B_HALTED];

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            case (addr)
                ADDR_W'(A_CFG):  regs_d.pol = wdata[B_POL_LO +: 4];
                ADDR_W'(A_HSW):  regs_d.hsw = wdata[SYNC_W-1:0];
                ADDR_W'(A_VSW):  regs_d.vsw = wdata[SYNC_W-1:0];
                ADDR_W'(A_TOT): begin
                    regs_d.htot = w_hi;
                    regs_d.vtot = w_lo;
                end
                ADDR_W'(A_HWIN): begin
                    regs_d.hbeg = w_hi;
                    regs_d.hend = w_lo;
                end
                ADDR_W'(A_VWIN): begin
                    regs_d.vbeg = w_hi;
                    regs_d.vend = w_lo;
                end
                default: ;
            endcase
        end
        // the stop event wins over a clear in the same cycle
        if (halt_evt)      regs_d.halted = 1'b1;
        else if (stat_clr) regs_d.halted = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_CFG):  rdata[B_POL_LO +: 4] = regs_q.pol;
            ADDR_W'(A_HSW):  rdata[SYNC_W-1:0]    = regs_q.hsw;
            ADDR_W'(A_VSW):  rdata[SYNC_W-1:0]    = regs_q.vsw;
            ADDR_W'(A_TOT): begin
                rdata[HALF +: CNT_W] = regs_q.htot;
                rdata[CNT_W-1:0]     = regs_q.vtot;
            end
            ADDR_W'(A_HWIN): begin
                rdata[HALF +: CNT_W] = regs_q.hbeg;
                rdata[CNT_W-1:0]     = regs_q.hend;
            end
            ADDR_W'(A_VWIN): begin
                rdata[HALF +: CNT_W] = regs_q.vbeg;
                rdata[CNT_W-1:0]     = regs_q.vend;
            end
            ADDR_W'(A_CTRL): begin
                rdata[B_RUN]  = active;
                rdata[B_STOP] = draining;
            end
            ADDR_W'(A_STAT): rdata[B_HALTED] = regs_q.halted;
            default: ;
        endcase
    end

    assign hsw    = regs_q.hsw;
    assign vsw    = regs_q.vsw;
    assign htot   = regs_q.htot;
    assign vtot   = regs_q.vtot;
    assign hbeg   = regs_q.hbeg;
    assign hend   = regs_q.hend;
    assign vbeg   = regs_q.vbeg;
    assign vend   = regs_q.vend;
    assign pol    = regs_q.pol;
    assign halted = regs_q.halted;

    a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !halt_evt) |=> !halted)
        else $error("R9: stopped flag not cleared");

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !stat_clr) |=> halted)
        else $error("R9: stopped flag lost");

endmodule

// File: rtl/lcd_rt_seq.sv
module lcd_rt_seq
    import lcd_rt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_run,
    input  logic ctrl_stop,
    input  logic frame_end,
    output logic start,
    output logic halt_evt,
    output logic active,
    output logic draining
);

    typedef struct packed {
        run_state_e st;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        start    = 1'b0;
        halt_evt = 1'b0;
        case (seq_q.st)
            RS_STOP: begin
                if (ctrl_wr && ctrl_run && !ctrl_stop) begin
                    seq_d.st = RS_RUN;
                    start    = 1'b1;
                end
            end
            RS_RUN: begin
                if (ctrl_wr && ctrl_stop) seq_d.st = RS_DRAIN;
            end
            RS_DRAIN: begin
                if (frame_end) begin
                    seq_d.st = RS_STOP;
                    halt_evt = 1'b1;
                end
            end
            default: seq_d.st = RS_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: RS_STOP};
        else        seq_q <= seq_d;
    end

    assign active   = (seq_q.st != RS_STOP);
    assign draining = (seq_q.st == RS_DRAIN);

    a_r8_halt_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && frame_end) |=> !active)
        else $error("R8: raster did not halt at frame end");

    a_r8_drain_until_end: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && !frame_end) |=> draining)
        else $error("R8: raster stopped early");

    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !draining && !(ctrl_wr && ctrl_stop)) |=> (active && !draining))
        else $error("R7: running raster changed state");

endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
    import lcd_rt_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SYNC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              lcd_hsync,
    output logic              lcd_vsync,
    output logic              lcd_de,
    output logic              lcd_pclk_inv,
    output logic              pix_req,
    output logic [CNT_W-1:0]  h_pos,
    output logic [CNT_W-1:0]  v_pos
);

    localparam int unsigned N_AXIS = 2;

    logic              ctrl_wr, ctrl_run, ctrl_stop;
    logic              start, halt_evt, active, draining, halted;
    logic [SYNC_W-1:0] hsw, vsw;
    logic [CNT_W-1:0]  htot, vtot, hbeg, hend, vbeg, vend;
    logic [3:0]        pol;

    logic [CNT_W-1:0]  tot_a  [N_AXIS];
    logic [CNT_W-1:0]  beg_a  [N_AXIS];
    logic [CNT_W-1:0]  end_a  [N_AXIS];
    logic [SYNC_W-1:0] sw_a   [N_AXIS];
    logic [CNT_W-1:0]  cnt_a  [N_AXIS];
    logic [N_AXIS-1:0] wrap_a;
    logic [N_AXIS-1:0] in_win;
    logic [N_AXIS-1:0] in_sync;
    logic              frame_end;
    logic              de_raw;

    lcd_rt_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .SYNC_W (SYNC_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .halt_evt (halt_evt),
        .active   (active),
        .draining (draining),
        .ctrl_wr  (ctrl_wr),
        .ctrl_run (ctrl_run),
        .ctrl_stop(ctrl_stop),
        .hsw      (hsw),
        .vsw      (vsw),
        .htot     (htot),
        .vtot     (vtot),
        .hbeg     (hbeg),
        .hend     (hend),
        .vbeg     (vbeg),
        .vend     (vend),
        .pol      (pol),
        .halted   (halted)
    );

    lcd_rt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_run  (ctrl_run),
        .ctrl_stop (ctrl_stop),
        .frame_end (frame_end),
        .start     (start),
        .halt_evt  (halt_evt),
        .active    (active),
        .draining  (draining)
    );

    assign tot_a[0] = htot;
    assign tot_a[1] = vtot;
    assign beg_a[0] = hbeg;
    assign beg_a[1] = vbeg;
    assign end_a[0] = hend;
    assign end_a[1] = vend;
    assign sw_a[0]  = hsw;
    assign sw_a[1]  = vsw;

    for (genvar gi = 0; gi < N_AXIS; gi++) begin : g_axis
        logic adv;
        if (gi == 0) begin : g_line
            assign adv = active;
        end else begin : g_frame
            assign adv = active && wrap_a[gi-1];
        end

        lcd_rt_axis_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (start),
            .advance (adv),
            .total   (tot_a[gi]),
            .count   (cnt_a[gi]),
            .wrap    (wrap_a[gi])
        );

        assign in_win[gi]  = (cnt_a[gi] >= beg_a[gi]) && (cnt_a[gi] < end_a[gi]);
        assign in_sync[gi] = (cnt_a[gi] < CNT_W'(sw_a[gi]));
    end

    assign frame_end    = &wrap_a;
    assign de_raw       = active && (&in_win);

    assign lcd_hsync    = (active && in_sync[0]) ^ pol[P_HS];
    assign lcd_vsync    = (active && in_sync[1]) ^ pol[P_VS];
    assign lcd_de       = de_raw ^ pol[P_DE];
    assign lcd_pclk_inv = pol[P_PCLK];
    assign pix_req      = de_raw;
    assign h_pos        = cnt_a[0];
    assign v_pos        = cnt_a[1];

    a_r7_start_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (h_pos == '0 && v_pos == '0))
        else $error("R7: raster did not start at origin");

    a_r8_flag_with_halt: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (halted && h_pos == '0 && v_pos == '0))
        else $error("R8: halt without flag or origin");

    a_r5_req_only_active: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |-> draining || (bus_rdata == bus_rdata && active))
        else $error("R5: pixel request while stopped");

endmodule

// File: tb/tb_lcd_raster_timer.sv
module tb_lcd_raster_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lcd_hsync, lcd_vsync, lcd_de, lcd_pclk_inv, pix_req;
    logic [15:0] h_pos, v_pos;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit cmp_on = 0;

    // reference model state
    int m_state = 0;   // 0 stopped, 1 running, 2 stopping
    int m_h = 0, m_v = 0;
    int m_hsw = 0, m_vsw = 0, m_ht = 0, m_vt = 0;
    int m_hb = 0, m_he = 0, m_vb = 0, m_ve = 0;
    int m_pol = 0;
    int m_halt = 0;

    always #10 clk = ~clk;   // 50 MHz

    lcd_raster_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcd_hsync(lcd_hsync),
        .lcd_vsync(lcd_vsync), .lcd_de(lcd_de), .lcd_pclk_inv(lcd_pclk_inv),
        .pix_req(pix_req), .h_pos(h_pos), .v_pos(v_pos)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural model, one update per clock edge
    always @(posedge clk) begin : model
        int  ns;
        bit  hw, vw, fe, st, halt;
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_h = 0; m_v = 0; m_hsw = 0; m_vsw = 0; m_ht = 0; m_vt = 0;
            m_hb = 0; m_he = 0; m_vb = 0; m_ve = 0; m_pol = 0; m_halt = 0;
        end else begin
            hw = (m_h + 1 >= m_ht);
            vw = (m_v + 1 >= m_vt);
            fe = hw && vw;
            ns = m_state; st = 0; halt = 0;
            if (bus_wr && bus_addr == 6) begin
                if (bus_wdata[4]) begin
                    if (m_state == 1) ns = 2;
                end else if (bus_wdata[3] && m_state == 0) begin
                    ns = 1; st = 1;
                end
            end
            if (m_state == 2 && fe) begin ns = 0; halt = 1; end
            if (st) begin
                m_h = 0; m_v = 0;
            end else if (m_state != 0) begin
                if (hw) begin
                    m_h = 0;
                    m_v = vw ? 0 : m_v + 1;
                end else m_h = m_h + 1;
            end
            if (halt) m_halt = 1;
            else if (bus_wr && bus_addr == 7 && !bus_wdata[0]) m_halt = 0;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_pol = int'(bus_wdata[11:8]);
                    3'd1: m_hsw = int'(bus_wdata[9:0]);
                    3'd2: m_vsw = int'(bus_wdata[9:0]);
                    3'd3: begin m_ht = int'(bus_wdata[31:16]); m_vt = int'(bus_wdata[15:0]); end
                    3'd4: begin m_hb = int'(bus_wdata[31:16]); m_he = int'(bus_wdata[15:0]); end
                    3'd5: begin m_vb = int'(bus_wdata[31:16]); m_ve = int'(bus_wdata[15:0]); end
                    default: ;
                endcase
            end
            m_state = ns;
        end
    end

    function automatic logic [31:0] exp_rdata(input int a);
        case (a)
            0: return 32'(m_pol) << 8;
            1: return 32'(m_hsw);
            2: return 32'(m_vsw);
            3: return (32'(m_ht) << 16) | 32'(m_vt);
            4: return (32'(m_hb) << 16) | 32'(m_he);
            5: return (32'(m_vb) << 16) | 32'(m_ve);
            6: return ((m_state != 0) ? 32'h8 : 32'h0) | ((m_state == 2) ? 32'h10 : 32'h0);
            default: return 32'(m_halt);
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            bit act, hs, vs, de;
            act = (m_state != 0);
            hs  = act && (m_h < m_hsw);
            vs  = act && (m_v < m_vsw);
            de  = act && m_h >= m_hb && m_h < m_he && m_v >= m_vb && m_v < m_ve;
            chk("R3 h_pos", 32'(h_pos), 32'(m_h));
            chk("R3 v_pos", 32'(v_pos), 32'(m_v));
            chk("R4/R6 hsync", 32'(lcd_hsync), 32'(hs ^ m_pol[3]));
            chk("R4/R6 vsync", 32'(lcd_vsync), 32'(vs ^ m_pol[0]));
            chk("R5/R6 de", 32'(lcd_de), 32'(de ^ m_pol[1]));
            chk("R5 pix_req", 32'(pix_req), 32'(de));
            chk("R6 pclk_inv", 32'(lcd_pclk_inv), 32'(m_pol[2]));
            case (bus_addr)
                3'd6:    chk("R10 ctrl read", bus_rdata, exp_rdata(6));
                3'd7:    chk("R9 status read", bus_rdata, exp_rdata(7));
                default: chk("R2 reg read", bus_rdata, exp_rdata(int'(bus_addr)));
            endcase
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic set_addr(input logic [2:0] a);
        @(posedge clk); #2;
        bus_addr = a;
    endtask

    task automatic wait_stopped();
        for (int i = 0; i < 500; i++) begin
            if (m_state == 0) break;
            @(posedge clk); #1;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 hsync", 32'(lcd_hsync), 0);
        chk("R1 de", 32'(lcd_de), 0);
        chk("R1 pix_req", 32'(pix_req), 0);
        chk("R1 pclk_inv", 32'(lcd_pclk_inv), 0);
        chk("R1 h_pos", 32'(h_pos), 0);
        chk("R1 reg 0", bus_rdata, 0);
        cmp_on = 1;

        // R2 first setup: window inside the frame, wide sync write
        wr(3'd1, 32'hFFFF_FC02);
        wr(3'd2, 32'd1);
        wr(3'd3, {16'd10, 16'd6});
        wr(3'd4, {16'd3, 16'd8});
        wr(3'd5, {16'd2, 16'd5});
        for (int a = 0; a < 6; a++) begin
            set_addr(3'(a));
            @(negedge clk);
        end
        set_addr(3'd1);
        @(negedge clk);
        chk("R2 sync width low bits", bus_rdata, 32'd2);

        // R7 start
        wr(3'd6, 32'h8);
        @(negedge clk);
        chk("R7 start h_pos", 32'(h_pos), 0);
        chk("R7 start active", bus_rdata, 32'h8);
        repeat (130) @(posedge clk);
        wr(3'd6, 32'h8);                 // R7 enable while running: no effect
        repeat (25) @(posedge clk);

        // R6 polarity, all then partial
        wr(3'd0, 32'h0000_0F00);
        repeat (70) @(posedge clk);
        wr(3'd0, 32'h0000_0A00);
        repeat (20) @(posedge clk);

        // R8 graceful stop mid-frame
        wr(3'd6, 32'h10);
        set_addr(3'd7);
        #1 wait_stopped();
        @(negedge clk);
        chk("R8 stopped flag", bus_rdata, 32'h1);
        chk("R8 h_pos at stop", 32'(h_pos), 0);

        // R9 flag handling
        wr(3'd7, 32'h1);
        @(negedge clk);
        chk("R9 write 1 keeps flag", bus_rdata, 32'h1);
        wr(3'd7, 32'h0);
        set_addr(3'd7);
        @(negedge clk);
        chk("R9 write 0 clears", bus_rdata, 32'h0);
        wr(3'd6, 32'h10);
        set_addr(3'd7);
        @(negedge clk);
        chk("R9 stop while stopped", bus_rdata, 32'h0);

        // R7 both bits: stop only
        wr(3'd6, 32'h18);
        @(negedge clk);
        chk("R7 both bits no start", bus_rdata, 32'h0);

        // second setup: window flush with edges, zero hsync, full vsync
        wr(3'd0, 32'h0);
        wr(3'd3, {16'd7, 16'd4});
        wr(3'd4, {16'd0, 16'd7});
        wr(3'd5, {16'd0, 16'd4});
        wr(3'd1, 32'd0);
        wr(3'd2, 32'd4);
        wr(3'd6, 32'h8);
        repeat (30) @(posedge clk);
        // R8 stop request landing on the final edge of a frame
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (m_h == 5 && m_v == 3) break;
        end
        wr(3'd6, 32'h10);
        #1;
        n = 0;
        for (int i = 0; i < 200; i++) begin
            if (m_state == 0) break;
            @(posedge clk); #1;
            n++;
        end
        chk("R8 full extra frame", 32'(n), 32'd28);
        set_addr(3'd7);
        @(negedge clk);
        chk("R8 flag after drain", bus_rdata, 32'h1);
        repeat (5) @(posedge clk);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule